// File: doc/BRIEF.md
# Segment Descriptor Load Sequencer

This block loads a segment register from a descriptor table in memory. A request carries a 16-bit selector and the offset currently in use. The sequencer first looks in a small cache of descriptors it has already validated. On a hit it installs the cached copy one cycle later and does not touch memory. On a miss it reads the 64-bit descriptor as two 32-bit words and checks its control fields. If the checks pass, it sets the accessed flag in the upper word and writes only that word back. It then compares the offset with the new segment limit, installs the segment and caches the descriptor. The cache holds the most recently loaded entries.

A descriptor that fails a check ends the load with a fault and a 2-bit cause. In that case nothing is written back, the segment register keeps its old value and the cache is left as it was. An offset beyond the new limit never faults, but it adds one cycle to the load. The memory port uses a request/acknowledge handshake and accepts any number of wait cycles. The cache has `CACHE_ENTRIES` entries, 6 by default, and works with any count of 2 or more.

Descriptor layout, with `lo` the word at the entry address and `hi` the word at +4:

| Field | Bits |
|-------|------|
| base | {hi[31:24], hi[7:0], lo[31:16]} |
| limit | {hi[19:16], lo[15:0]} |
| granularity | hi[23] |
| reserved | hi[21] |
| present | hi[15] |
| code/data class | hi[12] |
| type | hi[11:8], where hi[8] is the accessed flag |

Top module: `seg_load_seq`

## Requirements
- R1: `req_ready_o` is high only while the sequencer is idle. A request is taken when `req_valid_i` and `req_ready_o` are both high. A request presented while busy is ignored. `done_o` is a single-cycle pulse for each accepted request.
- R2: A miss runs these memory accesses in order:
  - a read at `tbl_base_i + 8*sel[15:3]` (the low word);
  - a read at that address +4 (the high word);
  - on successful validation only, a write to +4 of the high word with bit 8 (accessed) set.

  The low word is never written.
- R3: While `mem_req_o` is high and `mem_ack_i` is low, the request, address, write enable and write data hold steady. The sequencer completes correctly for any number of wait cycles.
- R4: A successful load installs these fields:
  - `seg_sel_o` is the full selector;
  - `seg_base_o` is {hi[31:24], hi[7:0], lo[31:16]};
  - `seg_limit_o` is the 20-bit limit {hi[19:16], lo[15:0]}, scaled to (limit<<12)|0xFFF when hi[23] is set;
  - `seg_type_o` is hi[11:8] with bit 0 (accessed) forced to 1.
- R5: Validation sets `fault_o` together with `done_o`, with `fault_cause_o` chosen by first match:
  - 2'b01 when the present bit hi[15] is 0;
  - 2'b10 for a bad type, meaning hi[12]=0, or hi[11]=1 with hi[9]=0 (non-readable code);
  - 2'b11 when the reserved bit hi[21] is 1.
- R6: A faulting load performs no write, leaves all segment outputs unchanged and is not cached, so reloading the same selector reads memory again.
- R7: When the offset exceeds the effective limit, no fault is raised. The miss takes exactly one cycle more than the same load with an offset within the limit.
- R8: On a cache hit, `done_o` rises in the cycle after acceptance. There is no memory access, and the cached descriptor, with accessed set, is installed.
- R9: A successful miss allocates the least recently used entry. Both hits and allocations make an entry the most recently used.
- R10: A one-cycle pulse on `flush_i` invalidates every cache entry, so the next load of any selector is a miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all cache entries |
| tbl_base_i | input | 32 | Descriptor table base address, 8-byte aligned |
| req_valid_i | input | 1 | Load request valid |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_sel_i | input | 16 | Selector; bits 15:3 index the table |
| req_off_i | input | 32 | Current offset for the limit check |
| done_o | output | 1 | Load finished (pulse) |
| fault_o | output | 1 | Load aborted by validation (with done_o) |
| fault_cause_o | output | 2 | Fault cause code, zero when no fault |
| seg_sel_o | output | 16 | Installed selector |
| seg_base_o | output | 32 | Installed segment base |
| seg_limit_o | output | 32 | Installed effective limit |
| seg_type_o | output | 4 | Installed type, bit 0 accessed |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle per access |
| mem_rdata_i | input | 32 | Memory read data, valid with ack |

## Verification
The assertions rely on three properties of the inputs:
- the table base is 8-byte aligned, so the write-back address ends in 3'b100;
- the memory raises `mem_ack_i` for exactly one cycle per access, and only while `mem_req_o` is high;
- `flush_i` is not pulsed while a load is in flight, unless losing that allocation is acceptable.

The bench's memory model acknowledges only requests it has seen, with a programmable wait from 0 to 3 cycles. It keeps the base aligned. It pulses flush only between loads.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_LO, ST_RD_HI, ST_CHECK, ST_WB, ST_LIMIT, ST_LIMIT_X, ST_FIN
  } seq_state_e;

  localparam logic [1:0] CAUSE_NONE   = 2'b00;
  localparam logic [1:0] CAUSE_ABSENT = 2'b01;
  localparam logic [1:0] CAUSE_TYPE   = 2'b10;
  localparam logic [1:0] CAUSE_RSVD   = 2'b11;

  localparam int unsigned ACC_BIT  = 40;
  localparam int unsigned DESC_W   = 64;
  localparam int unsigned WORD_W   = 32;

  function automatic logic [31:0] desc_base(input logic [63:0] d);
    return {d[63:56], d[39:32], d[31:16]};
  endfunction

  function automatic logic [31:0] desc_limit(input logic [63:0] d);
    logic [19:0] raw;
    raw = {d[51:48], d[15:0]};
    return d[55] ? {raw, 12'hfff} : {12'h000, raw};
  endfunction

  function automatic logic [3:0] desc_type(input logic [63:0] d);
    return d[43:40];
  endfunction
endpackage

// File: rtl/seg_desc_check.sv
module seg_desc_check
  import seg_pkg::*;
(
  input  logic [63:0] desc_i,
  input  logic [31:0] off_i,
  output logic        ok_o,
  output logic [1:0]  cause_o,
  output logic        viol_o
);
  logic present, is_seg, is_code, readable, rsvd;

  assign present  = desc_i[47];
  assign is_seg   = desc_i[44];
  assign is_code  = desc_i[43];
  assign readable = desc_i[41];
  assign rsvd     = desc_i[53];

  always_comb begin
    if (!present)                        cause_o = CAUSE_ABSENT;
    else if (!is_seg || (is_code && !readable)) cause_o = CAUSE_TYPE;
    else if (rsvd)                       cause_o = CAUSE_RSVD;
    else                                 cause_o = CAUSE_NONE;
  end

  assign ok_o   = (cause_o == CAUSE_NONE);
  assign viol_o = off_i > desc_limit(desc_i);
endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache #(
  parameter int unsigned ENTRIES = 6,
  parameter int unsigned TAG_W   = 13,
  parameter int unsigned DATA_W  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [TAG_W-1:0]  lookup_tag_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] hit_data_o,
  input  logic              touch_i,
  input  logic              alloc_i,
  input  logic [TAG_W-1:0]  alloc_tag_i,
  input  logic [DATA_W-1:0] alloc_data_i
);
  localparam int unsigned AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [AW-1:0] OLDEST = AW'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic [AW-1:0]      age_q  [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [AW-1:0]      hit_way, victim, upd_way;
  logic               upd;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign match[g] = valid_q[g] && (tag_q[g] == lookup_tag_i);
  end

  assign hit_o = |match;

  always_comb begin
    hit_way    = '0;
    hit_data_o = '0;
    victim     = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hit_way    = AW'(i);
        hit_data_o = data_q[i];
      end
      if (age_q[i] == OLDEST) victim = AW'(i);
    end
  end

  assign upd     = touch_i || alloc_i;
  assign upd_way = alloc_i ? victim : hit_way;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
        age_q[i]  <= AW'(i);
      end
    end else begin
      if (flush_i) valid_q <= '0;
      else if (alloc_i) begin
        valid_q[upd_way] <= 1'b1;
        tag_q[upd_way]   <= alloc_tag_i;
        data_q[upd_way]  <= alloc_data_i;
      end
      if (upd) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (AW'(i) == upd_way)            age_q[i] <= '0;
          else if (age_q[i] < age_q[upd_way]) age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/seg_load_seq.sv
module seg_load_seq
  import seg_pkg::*;
#(
  parameter int unsigned CACHE_ENTRIES = 6,
  parameter int unsigned SEL_W         = 16,
  parameter int unsigned ADDR_W        = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [SEL_W-1:0]  req_sel_i,
  input  logic [31:0]       req_off_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [1:0]        fault_cause_o,
  output logic [SEL_W-1:0]  seg_sel_o,
  output logic [31:0]       seg_base_o,
  output logic [31:0]       seg_limit_o,
  output logic [3:0]        seg_type_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i
);
  localparam int unsigned IDX_W = SEL_W - 3;

  seq_state_e          state_q;
  logic [SEL_W-1:0]    sel_q;
  logic [31:0]         off_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DESC_W-1:0]   desc_q;
  logic                miss_q, fault_q;
  logic [1:0]          cause_q;
  logic                accept, cache_hit, chk_ok, chk_viol, alloc;
  logic [DESC_W-1:0]   cache_data;
  logic [1:0]          chk_cause;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign alloc       = (state_q == ST_FIN) && miss_q && !fault_q;

  seg_desc_cache #(
    .ENTRIES (CACHE_ENTRIES),
    .TAG_W   (IDX_W),
    .DATA_W  (DESC_W)
  ) u_cache (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .lookup_tag_i (req_sel_i[SEL_W-1:3]),
    .hit_o        (cache_hit),
    .hit_data_o   (cache_data),
    .touch_i      (accept && cache_hit),
    .alloc_i      (alloc),
    .alloc_tag_i  (sel_q[SEL_W-1:3]),
    .alloc_data_i (desc_q)
  );

  seg_desc_check u_check (
    .desc_i  (desc_q),
    .off_i   (off_q),
    .ok_o    (chk_ok),
    .cause_o (chk_cause),
    .viol_o  (chk_viol)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sel_q      <= '0;
      off_q      <= '0;
      addr_q     <= '0;
      desc_q     <= '0;
      miss_q     <= 1'b0;
      fault_q    <= 1'b0;
      cause_q    <= CAUSE_NONE;
      seg_sel_o  <= '0;
      seg_base_o <= '0;
      seg_limit_o <= '0;
      seg_type_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          sel_q   <= req_sel_i;
          off_q   <= req_off_i;
          addr_q  <= tbl_base_i + ADDR_W'({req_sel_i[SEL_W-1:3], 3'b000});
          fault_q <= 1'b0;
          cause_q <= CAUSE_NONE;
          miss_q  <= !cache_hit;
          if (cache_hit) begin
            desc_q  <= cache_data;
            state_q <= ST_FIN;
          end else begin
            state_q <= ST_RD_LO;
          end
        end
        ST_RD_LO: if (mem_ack_i) begin
          desc_q[31:0] <= mem_rdata_i;
          state_q      <= ST_RD_HI;
        end
        ST_RD_HI: if (mem_ack_i) begin
          desc_q[63:32] <= mem_rdata_i;
          state_q       <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!chk_ok) begin
            fault_q <= 1'b1;
            cause_q <= chk_cause;
            state_q <= ST_FIN;
          end else begin
            desc_q[ACC_BIT] <= 1'b1;
            state_q         <= ST_WB;
          end
        end
        ST_WB:      if (mem_ack_i) state_q <= ST_LIMIT;
        ST_LIMIT:   state_q <= chk_viol ? ST_LIMIT_X : ST_FIN;
        ST_LIMIT_X: state_q <= ST_FIN;
        ST_FIN: begin
          state_q <= ST_IDLE;
          if (!fault_q) begin
            seg_sel_o   <= sel_q;
            seg_base_o  <= desc_base(desc_q);
            seg_limit_o <= desc_limit(desc_q);
            seg_type_o  <= desc_type(desc_q);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o        = (state_q == ST_FIN);
  assign fault_o       = done_o && fault_q;
  assign fault_cause_o = fault_o ? cause_q : CAUSE_NONE;
  assign mem_req_o     = (state_q == ST_RD_LO) || (state_q == ST_RD_HI) || (state_q == ST_WB);
  assign mem_we_o      = (state_q == ST_WB);
  assign mem_addr_o    = addr_q + ((state_q == ST_RD_LO) ? ADDR_W'(0) : ADDR_W'(4));
  assign mem_wdata_o   = desc_q[63:32];
endmodule

// File: rtl/seg_load_seq_chk.sv
module seg_load_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        flush_i,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        done_o,
  input logic        fault_o,
  input logic [1:0]  fault_cause_o,
  input logic [15:0] seg_sel_o,
  input logic [31:0] seg_base_o,
  input logic [31:0] seg_limit_o,
  input logic [3:0]  seg_type_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_ack_i,
  input logic        hit_i
);
  assert_busy_not_ready_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || done_o) |-> !req_ready_o);

  assert_done_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_wb_accessed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_wdata_o[8] && mem_addr_o[2:0] == 3'b100));

  assert_mem_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_we_o) && $stable(mem_wdata_o)));

  assert_install_accessed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o) |=> seg_type_o[0]);

  assert_fault_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (done_o && fault_cause_o != 2'b00));

  assert_fault_keeps_seg_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |=> ($stable(seg_sel_o) && $stable(seg_base_o) &&
                             $stable(seg_limit_o) && $stable(seg_type_o)));

  assert_hit_one_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && hit_i) |=> (done_o && !fault_o && !mem_req_o));

  assert_flush_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hit_i);
endmodule

bind seg_load_seq seg_load_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .flush_i       (flush_i),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .done_o        (done_o),
  .fault_o       (fault_o),
  .fault_cause_o (fault_cause_o),
  .seg_sel_o     (seg_sel_o),
  .seg_base_o    (seg_base_o),
  .seg_limit_o   (seg_limit_o),
  .seg_type_o    (seg_type_o),
  .mem_req_o     (mem_req_o),
  .mem_we_o      (mem_we_o),
  .mem_addr_o    (mem_addr_o),
  .mem_wdata_o   (mem_wdata_o),
  .mem_ack_i     (mem_ack_i),
  .hit_i         (cache_hit)
);

// File: tb/seg_load_seq_tb_top.sv
`timescale 1ns/1ps
module seg_load_seq_tb_top;
  localparam logic [31:0] TBL = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_sel = '0;
  logic [31:0] req_off = '0;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        req_ready, done, fault, mem_req, mem_we;
  logic [1:0]  cause;
  logic [15:0] seg_sel;
  logic [31:0] seg_base, seg_limit, mem_addr, mem_wdata;
  logic [3:0]  seg_type;

  logic [31:0] mem [0:255];
  int wait_cfg = 0;
  int rd_cnt = 0, wr_cnt = 0;
  int nvec = 0, nfail = 0;

  always #4 clk = ~clk;

  seg_load_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .tbl_base_i(TBL),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_sel_i(req_sel),
    .req_off_i(req_off), .done_o(done), .fault_o(fault), .fault_cause_o(cause),
    .seg_sel_o(seg_sel), .seg_base_o(seg_base), .seg_limit_o(seg_limit),
    .seg_type_o(seg_type), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] e_base(input int idx);
    return 32'h1000_0000 + 32'(idx) * 32'h0001_0203;
  endfunction
  function automatic logic [19:0] e_lim(input int idx);
    return 20'h00100 + 20'(idx) * 20'h00111;
  endfunction
  function automatic logic e_g(input int idx);
    return (idx % 3) == 0;
  endfunction
  function automatic logic [31:0] e_eff(input int idx);
    return e_g(idx) ? {e_lim(idx), 12'hfff} : {12'h000, e_lim(idx)};
  endfunction
  // idx bits: [6] present, [5] class, [4] reserved, [3:0] type
  function automatic logic [31:0] mk_lo(input int idx);
    logic [31:0] b; logic [19:0] l;
    b = e_base(idx); l = e_lim(idx);
    return {b[15:0], l[15:0]};
  endfunction
  function automatic logic [31:0] mk_hi(input int idx);
    logic [31:0] b; logic [19:0] l; logic [7:0] ib;
    b = e_base(idx); l = e_lim(idx); ib = 8'(idx);
    return {b[31:24], e_g(idx), 1'b0, ib[4], 1'b0, l[19:16], ib[6], 2'b00, ib[5], ib[3:0], b[23:16]};
  endfunction
  function automatic logic [1:0] e_cause(input int idx);
    logic [7:0] ib;
    ib = 8'(idx);
    if (!ib[6]) return 2'b01;
    if (!ib[5] || (ib[3] && !ib[1])) return 2'b10;
    if (ib[4]) return 2'b11;
    return 2'b00;
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  // memory model: one-cycle ack after wait_cfg idle cycles
  initial begin
    int wcnt;
    int w;
    wcnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (wcnt >= wait_cfg) begin
          wcnt = 0;
          mem_ack = 1'b1;
          w = int'((mem_addr - TBL) >> 2);
          if (mem_we) begin mem[w] = mem_wdata; wr_cnt++; end
          else begin mem_rdata = mem[w]; rd_cnt++; end
        end else wcnt++;
      end
    end
  end

  task automatic load(input int idx, input logic [31:0] off,
                      output int lat, output logic f, output logic [1:0] c);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_sel = {13'(idx), 3'(idx)};
    req_off = off;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done) begin @(negedge clk); lat++; end
    f = fault; c = cause;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    int lat, lat2, rd0, wr0;
    logic f;
    logic [1:0] c;
    logic [31:0] pbase;
    logic [15:0] psel;
    for (int i = 0; i < 128; i++) begin
      mem[2*i] = mk_lo(i); mem[2*i+1] = mk_hi(i);
    end
    for (int i = 256 - 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", req_ready, 1);
    chk("R1 reset done", done, 0);
    chk("R3 reset mem_req", mem_req, 0);
    chk("R4 reset base", seg_base, 0);

    // validation sweep over present/class/reserved/type with varying wait
    pbase = 0; psel = 0;
    for (int i = 0; i < 128; i++) begin
      wait_cfg = i % 4;
      rd0 = rd_cnt; wr0 = wr_cnt;
      load(i, 32'h0, lat, f, c);
      chk("R5 fault", f, e_cause(i) != 0);
      chk("R5 cause", c, e_cause(i));
      chk("R2 reads", rd_cnt - rd0, 2);
      chk("R2 low word untouched", mem[2*i], mk_lo(i));
      if (e_cause(i) == 0) begin
        chk("R2 one write", wr_cnt - wr0, 1);
        chk("R2 accessed in memory", mem[2*i+1], mk_hi(i) | 32'h100);
        chk("R4 sel", seg_sel, {13'(i), 3'(i)});
        chk("R4 base", seg_base, e_base(i));
        chk("R4 limit", seg_limit, e_eff(i));
        chk("R4 type", seg_type, {mk_hi(i)[11:9], 1'b1});
        pbase = e_base(i); psel = {13'(i), 3'(i)};
      end else begin
        chk("R6 no write", wr_cnt - wr0, 0);
        chk("R6 base kept", seg_base, pbase);
        chk("R6 sel kept", seg_sel, psel);
      end
    end

    // R6: faulting selector not cached
    wait_cfg = 1;
    rd0 = rd_cnt;
    load(3, 0, lat, f, c);
    chk("R6 refetch after fault", rd_cnt - rd0, 2);

    // R8: hit on a selector loaded during the sweep (cache holds last 6 valid)
    rd0 = rd_cnt; wr0 = wr_cnt;
    load(111, 0, lat, f, c);
    chk("R8 hit latency", lat, 1);
    chk("R8 no memory traffic", (rd_cnt - rd0) + (wr_cnt - wr0), 0);
    chk("R8 base", seg_base, e_base(111));
    chk("R8 type accessed", seg_type, {mk_hi(111)[11:9], 1'b1});

    // R10: flush
    @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
    rd0 = rd_cnt;
    load(111, 0, lat, f, c);
    chk("R10 miss after flush", rd_cnt - rd0, 2);

    // R7: limit violation adds one cycle, no fault (idx 97: G=0; idx 99: G=1)
    for (int k = 0; k < 2; k++) begin
      int id;
      id = (k == 0) ? 97 : 99;
      wait_cfg = 2;
      @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
      load(id, e_eff(id), lat, f, c);
      chk("R7 at limit no fault", f, 0);
      @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
      load(id, e_eff(id) + 1, lat2, f, c);
      chk("R7 over limit no fault", f, 0);
      chk("R7 one extra cycle", lat2 - lat, 1);
      chk("R7 installed limit", seg_limit, e_eff(id));
    end

    // R9: LRU replacement
    wait_cfg = 0;
    @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
    for (int s = 96; s < 102; s++) load(s, 0, lat, f, c);
    rd0 = rd_cnt; load(96, 0, lat, f, c);
    chk("R9 s96 hit", rd_cnt - rd0, 0);
    rd0 = rd_cnt; load(102, 0, lat, f, c);
    chk("R9 new miss", rd_cnt - rd0, 2);
    rd0 = rd_cnt; load(97, 0, lat, f, c);
    chk("R9 oldest evicted", rd_cnt - rd0, 2);
    rd0 = rd_cnt; load(96, 0, lat, f, c);
    chk("R9 recent kept", rd_cnt - rd0, 0);
    rd0 = rd_cnt; load(99, 0, lat, f, c);
    chk("R9 s99 kept", rd_cnt - rd0, 0);
    rd0 = rd_cnt; load(98, 0, lat, f, c);
    chk("R9 s98 evicted", rd_cnt - rd0, 2);

    // R1: request while busy is ignored
    begin
      int dcnt;
      wait_cfg = 1;
      @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
      req_valid = 1'b1; req_sel = {13'd100, 3'd0}; req_off = 0;
      @(negedge clk);
      req_sel = {13'd101, 3'd0};
      chk("R1 busy not ready", req_ready, 0);
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      dcnt = 0;
      repeat (30) begin
        if (done) dcnt++;
        @(negedge clk);
      end
      chk("R1 single done", dcnt, 1);
      chk("R1 first request kept", seg_sel, {13'd100, 3'd0});
    end

    summary();
    $finish;
  end
endmodule